// File: doc/BRIEF.md
# Four-Channel Reload-Counter PWM Generator

This block generates four pulse-width-modulated outputs that share one period. An 8-bit up-counter advances on each enabled counter tick. When it passes 255 it restarts from a programmable reload value, so the period is 256 minus the reload value, counted in ticks. Each channel keeps an active phase flag. A wrap of the counter sets the flag, and the counter landing on the channel's compare value clears it. The pin shows that flag through a per-channel inversion bit and a per-channel enable.

Software writes the reload value, the enable and inversion bits, and one duty value per channel through a single-cycle write port. The duty and reload values are buffered. They reach the counter and the channels only at the next wrap, so a running period is never cut short or stretched. A halt input freezes the counter and every channel in place. Setting the reload to 0 gives 256 duty steps, and the inversion bit then covers both the always-low and the always-high extreme.

Top module: `pwm_reload_timer`

## Requirements
- R1: Reset state. While reset is low and after it is released, all pins are 0. The counter, the reload value and every compare value are all 0.
- R2: The counter and every channel's phase advance only in cycles where `cnt_en` is 1 and `halt` is 0. In any other cycle they hold.
- R3: On a tick with the counter at 255, the counter loads the buffered reload value. On any other tick it adds 1. The period is therefore 256 minus the reload value, in ticks.
- R4: On a wrap, each channel whose compare value differs from the new reload value enters its active phase.
- R5: When a channel's compare value C is greater than reload value L, the channel is active exactly while the counter is below C. That gives C−L active ticks out of 256−L.
- R6: When C equals L, the channel stays idle for the whole period. When C is below L, it stays active for the whole period.
- R7: Pin i equals the phase of channel i XOR inversion bit i, for an enabled channel. An inversion-bit write shows on the pin in the cycle after the write.
- R8: While enable bit i is 0, pin i is 0 whatever the counter, phase or inversion bit.
- R9: A duty write goes to a buffer. It becomes the channel's compare value only at the next wrap.
- R10: A reload write goes to a buffer. It is used as the restart value, and as the active reload value, at the next wrap.
- R11: Write map, `wr_addr` with `wr_data`:
  - address 0 sets the reload value;
  - address 1 sets the enables in bits 3:0 and the inversion bits in bits 7:4, with bit i for channel i;
  - addresses 2 to 5 set the duty value of channels 0 to 3;
  - addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Counter tick enable |
| halt | input | 1 | Freezes counting and PWM generation while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 4 | PWM pins, bit i for channel i |

## Verification
Several rules are checked by assertions in every cycle:
- the counter's step-by-one and its reload at 255 (R3);
- the freeze when no tick occurs (R2);
- that compare and reload values move only at a wrap (R9, R10);
- that each channel's phase matches the counter window set by its compare and reload values (R5, R6).

The inversion and enable gating, the write map and the ignored addresses can only be shown by the bench. The same holds for the measured duty over whole periods. The bench sweeps every compare value from one below the reload up to 255 for several reload values, alternating inversion patterns. It checks the pins against an arithmetic model in every cycle and counts active ticks per period.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  localparam int CNT_W_DEF = 8;
  localparam int NCH_DEF   = 4;
  localparam int DUTY_BASE = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_RELOAD,
    SEL_CTRL,
    SEL_DUTY
  } reg_sel_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    wrap,
  output logic [NCH-1:0]          en_q,
  output logic [NCH-1:0]          pol_q,
  output logic [CW-1:0]           rel_sh_q,
  output logic [CW-1:0]           rel_act_q,
  output logic [NCH-1:0][CW-1:0]  cmp_act_q,
  output logic [NCH-1:0][CW-1:0]  cmp_nxt
);
  import pwm_reload_pkg::*;

  localparam logic [AW-1:0] A_RELOAD = AW'(0);
  localparam logic [AW-1:0] A_CTRL   = AW'(1);

  reg_sel_e                sel;
  logic [NCH-1:0]          duty_we;
  logic [NCH-1:0][CW-1:0]  duty_q, duty_d;
  logic [NCH-1:0]          en_d, pol_d;
  logic [CW-1:0]           rel_sh_d, rel_act_d;

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if (wr_en) begin
      if (wr_addr == A_RELOAD)                   sel = SEL_RELOAD;
      else if (wr_addr == A_CTRL)                sel = SEL_CTRL;
      else if (int'(wr_addr) < DUTY_BASE + NCH)  sel = SEL_DUTY;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_we
    assign duty_we[i] = (sel == SEL_DUTY) && (int'(wr_addr) == DUTY_BASE + i);
  end

  // next state
  always_comb begin
    en_d      = en_q;
    pol_d     = pol_q;
    rel_sh_d  = rel_sh_q;
    rel_act_d = rel_act_q;
    duty_d    = duty_q;
    case (sel)
      SEL_RELOAD: rel_sh_d = wr_data;
      SEL_CTRL: begin
        en_d  = wr_data[NCH-1:0];
        pol_d = wr_data[2*NCH-1:NCH];
      end
      SEL_DUTY: begin
        for (int i = 0; i < NCH; i++)
          if (duty_we[i]) duty_d[i] = wr_data;
      end
      default: ;
    endcase
    if (wrap) rel_act_d = rel_sh_q;
  end

  // compare values move only at a wrap, taking the buffered duty
  assign cmp_nxt = wrap ? duty_q : cmp_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      pol_q     <= '0;
      rel_sh_q  <= '0;
      rel_act_q <= '0;
      duty_q    <= '0;
      cmp_act_q <= '0;
    end else begin
      en_q      <= en_d;
      pol_q     <= pol_d;
      rel_sh_q  <= rel_sh_d;
      rel_act_q <= rel_act_d;
      duty_q    <= duty_d;
      cmp_act_q <= cmp_nxt;
    end
  end
endmodule

// File: rtl/pwm_base_counter.sv
module pwm_base_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] rel_sh,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  assign wrap = tick && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_nxt = cnt_q;
    if (wrap)      cnt_nxt = rel_sh;
    else if (tick) cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wrap,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] cmp_nxt,
  input  logic          en,
  input  logic          pol,
  output logic          phase_q,
  output logic          pin
);
  logic phase_d;

  // a match on the incoming count wins over the wrap set
  always_comb begin
    phase_d = phase_q;
    if (tick) begin
      if (cnt_nxt == cmp_nxt) phase_d = 1'b0;
      else if (wrap)          phase_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign pin = en & (phase_q ^ pol);
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int NCH = pwm_reload_pkg::NCH_DEF,
  parameter int CW  = pwm_reload_pkg::CNT_W_DEF,
  parameter int AW  = $clog2(NCH + pwm_reload_pkg::DUTY_BASE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic           halt,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o
);
  logic [1:0]              rst_pipe;
  logic                    rst_q_n;
  logic                    tick, wrap;
  logic [CW-1:0]           cnt_q, cnt_nxt, rel_sh, rel_act;
  logic [NCH-1:0]          en, pol, phase;
  logic [NCH-1:0][CW-1:0]  cmp_act, cmp_nxt;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign tick = cnt_en & ~halt;

  pwm_cfg_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wrap      (wrap),
    .en_q      (en),
    .pol_q     (pol),
    .rel_sh_q  (rel_sh),
    .rel_act_q (rel_act),
    .cmp_act_q (cmp_act),
    .cmp_nxt   (cmp_nxt)
  );

  pwm_base_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tick    (tick),
    .rel_sh  (rel_sh),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .tick    (tick),
      .wrap    (wrap),
      .cnt_nxt (cnt_nxt),
      .cmp_nxt (cmp_nxt[i]),
      .en      (en[i]),
      .pol     (pol[i]),
      .phase_q (phase[i]),
      .pin     (pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm_reload_timer_chk.sv
module pwm_reload_timer_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    wrap,
  input logic [CW-1:0]           cnt_q,
  input logic [CW-1:0]           rel_sh,
  input logic [CW-1:0]           rel_act,
  input logic [NCH-1:0][CW-1:0]  cmp_act,
  input logic [NCH-1:0]          phase
);
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  p_wrap_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == $past(rel_sh)));

  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt_q) && $stable(phase)));

  p_cmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cmp_act));

  p_reload_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(rel_act));

  p_reload_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (rel_act == $past(rel_sh)));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act[i] > rel_act) |-> (phase[i] == (cnt_q < cmp_act[i])));

    p_flat_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act[i] == rel_act) |-> !phase[i]);

    p_flat_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act[i] < rel_act) |-> phase[i]);
  end
endmodule

bind pwm_reload_timer pwm_reload_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .tick    (tick),
  .wrap    (wrap),
  .cnt_q   (cnt_q),
  .rel_sh  (rel_sh),
  .rel_act (rel_act),
  .cmp_act (cmp_act),
  .phase   (phase)
);

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;
  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int AW   = 3;
  localparam int MAXC = 255;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, cnt_en, halt, wr_en;
  logic [AW-1:0]  wr_addr;
  logic [CW-1:0]  wr_data;
  logic [NCH-1:0] pwm_o;

  pwm_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .halt(halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
  );

  int    n_run, n_fail, m_wraps;
  bit    done;
  string tag;

  // arithmetic model of the requirements
  int m_cnt, m_rel_sh, m_rel;
  int m_dcr [NCH];
  int m_cmp [NCH];
  logic [NCH-1:0] m_en, m_pol;

  function automatic logic [NCH-1:0] exp_vec();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) begin
      logic ph;
      if (m_cmp[i] > m_rel)       ph = (m_cnt < m_cmp[i]);   // R5
      else if (m_cmp[i] == m_rel) ph = 1'b0;                  // R6
      else                        ph = 1'b1;                  // R6
      v[i] = m_en[i] & (ph ^ m_pol[i]);                       // R7, R8
    end
    return v;
  endfunction

  task automatic check_pins(string t);
    logic [NCH-1:0] e;
    e = exp_vec();
    n_run++;
    if (pwm_o !== e) begin
      n_fail++;
      $display("FAIL %s: pwm_o=%b expected %b (count %0d)", t, pwm_o, e, m_cnt);
    end
  endtask

  task automatic model_tick();
    if (m_cnt == MAXC) begin                 // R3, R9, R10
      m_cnt = m_rel_sh;
      m_rel = m_rel_sh;
      for (int i = 0; i < NCH; i++) m_cmp[i] = m_dcr[i];
      m_wraps++;
    end else begin
      m_cnt++;
    end
  endtask

  task automatic cyc(input logic e, input logic h);
    cnt_en = e;
    halt   = h;
    @(posedge clk);
    #1;
    if (e && !h) model_tick();
    check_pins(tag);
  endtask

  task automatic wr(input int a, input int d);
    cnt_en  = 1'b0;
    halt    = 1'b0;
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = CW'(d);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    // R11 write map
    if (a == 0) m_rel_sh = d;
    else if (a == 1) begin
      m_en  = d[3:0];
      m_pol = d[7:4];
    end else if (a >= 2 && a <= 5) m_dcr[a-2] = d;
    check_pins(tag);
  endtask

  task automatic run(input int n);
    repeat (n) cyc(1'b1, 1'b0);
  endtask

  task automatic to_wrap();
    int w;
    w = m_wraps;
    while (m_wraps == w) cyc(1'b1, 1'b0);
  endtask

  // counts active ticks over one whole period (R5, R6, R7, R8)
  task automatic measure(string t);
    int p;
    int hi [NCH];
    to_wrap();
    p = 256 - m_rel;
    for (int i = 0; i < NCH; i++) hi[i] = 0;
    for (int k = 0; k < p; k++) begin
      if (k > 0) cyc(1'b1, 1'b0);
      for (int i = 0; i < NCH; i++) if (pwm_o[i]) hi[i]++;
    end
    for (int i = 0; i < NCH; i++) begin
      int ex;
      if (m_cmp[i] > m_rel)       ex = m_cmp[i] - m_rel;
      else if (m_cmp[i] == m_rel) ex = 0;
      else                        ex = p;
      if (m_pol[i]) ex = p - ex;
      if (!m_en[i]) ex = 0;
      n_run++;
      if (hi[i] != ex) begin
        n_fail++;
        $display("FAIL %s: ch%0d active ticks %0d expected %0d (reload %0d cmp %0d)",
                 t, i, hi[i], ex, m_rel, m_cmp[i]);
      end
    end
  endtask

  task automatic sweep(input int rel);
    int g;
    g = 0;
    tag = "R3";
    wr(0, rel);
    for (int base = rel - 1; base <= MAXC; base += 4) begin
      for (int i = 0; i < NCH; i++) wr(2 + i, (base + i > MAXC) ? MAXC : base + i);
      wr(1, (g % 2 == 1) ? 8'hAF : 8'h0F);
      measure("R5");
      g++;
    end
  endtask

  initial begin
    done = 1'b0; n_run = 0; n_fail = 0; m_wraps = 0;
    m_cnt = 0; m_rel_sh = 0; m_rel = 0; m_en = '0; m_pol = '0;
    for (int i = 0; i < NCH; i++) begin m_dcr[i] = 0; m_cmp[i] = 0; end
    rst_n = 1'b0; cnt_en = 1'b0; halt = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tag = "R1";

    // R1 reset state
    repeat (3) @(posedge clk);
    #1 check_pins("R1");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check_pins("R1");
    wr(1, 8'h0F);
    run(300);                      // compare == reload == 0: idle everywhere
    tag = "R7";
    wr(1, 8'hFF);
    run(20);                       // inverted idle: all pins high

    // three-tick period, compares around the reload value
    tag = "R4";
    wr(0, 8'hFD);
    wr(2, 8'hFC); wr(3, 8'hFD); wr(4, 8'hFE); wr(5, 8'hFF);
    wr(1, 8'h0F);
    measure("R6");
    measure("R5");
    wr(1, 8'hF0);
    tag = "R8";
    measure("R8");
    wr(1, 8'h5F);
    tag = "R7";
    measure("R7");

    // near-exhaustive compare sweeps
    sweep(8'hF0);
    sweep(8'hC0);
    sweep(8'hFD);
    tag = "R3";
    wr(0, 0);
    wr(2, 0); wr(3, 1); wr(4, 128); wr(5, 255);
    wr(1, 8'h0F);
    measure("R5");
    wr(1, 8'hFF);
    measure("R7");

    // R2 tick gating and halt
    tag = "R2";
    wr(0, 8'hE0);
    wr(2, 8'hE8); wr(3, 8'hF0); wr(4, 8'hFF); wr(5, 8'hE1);
    wr(1, 8'h2F);
    for (int k = 0; k < 900; k++) cyc(k % 3 != 0, (k / 40) % 4 == 1);

    // R8 disabled channels stay low, inverted or not
    tag = "R8";
    wr(1, 8'hF5);
    measure("R8");
    measure("R8");

    // R9 duty write in mid-period waits for the wrap
    tag = "R9";
    to_wrap();
    run(5);
    wr(2, 8'hFE);
    wr(3, 8'hE2);
    run(20);
    measure("R9");

    // R10 reload write in mid-period waits for the wrap
    tag = "R10";
    run(7);
    wr(0, 8'hD0);
    run(300);
    measure("R10");

    // R11 unused addresses change nothing
    tag = "R11";
    wr(6, 8'h00);
    wr(7, 8'hFF);
    run(100);
    measure("R11");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule